// File: doc/BRIEF.md
# Loadable Up/Down Counter Chain

This block is a synchronous binary counter built from identical 4-bit counting stages. Each stage counts up or down on every clock edge while its enable is low. It can take a parallel value on an edge when its load strobe is low, and an asynchronous clear forces it to zero at once. Each stage reports an active-low all-ones flag. The stages are chained so that a stage advances only on an edge where every stage below it reads 1111. Two stages give the default 8-bit width.

The chain's all-ones flag can also be fed back as a load strobe. In this wrap mode the counter does not roll over to zero. Instead it restarts from a programmable value, for example 0xFF followed by 0x06. This restricts the counting range without any external gates.

There is no data stream at the edge of this block, so every pin is a plain level-sensitive control or status signal.

Top module: `lud_counter_chain`

## Requirements
- R1: While clr is 1, count reads 0x00 at once, before any clock edge.
- R2: On an edge with cnt_en_n=0, load_n=1 and no wrap restart, the low nibble count[3:0] steps by +1 modulo 16 when dir_up=1 and by -1 modulo 16 when dir_up=0.
- R3: On such a counting edge, the high nibble count[7:4] steps in the same direction only if count[3:0] was 1111 before the edge; otherwise it holds. With dir_up=1 this gives plain binary +1 modulo 256.
- R4: On an edge with cnt_en_n=1, count holds its value. Neither load_data, load_n, wrap_en nor dir_up has any effect.
- R5: On an edge with cnt_en_n=0 and load_n=0, count takes load_data. This overrides counting and wrap, in either direction.
- R6: all_ones_n is 0 exactly when count is 0xFF and 1 otherwise. It follows count combinationally, whatever the value of dir_up.
- R7: On an edge with cnt_en_n=0, load_n=1, wrap_en=1 and count=0xFF, count takes restart_val, in either direction.
- R8: While clr is 1, clock edges leave count at 0x00, even with load or count requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| load_n | input | 1 | Parallel load strobe, active low |
| cnt_en_n | input | 1 | Counter enable, active low |
| wrap_en | input | 1 | 1 makes the all-ones state reload restart_val |
| load_data | input | 8 | Value taken on a parallel load |
| restart_val | input | 8 | Value taken on a wrap restart |
| count | output | 8 | Current count |
| all_ones_n | output | 1 | Low while count is all ones |

## Verification
A wrong internal state appears on count at the very next rising edge. The stages have no hidden pipeline, so a bad next-state choice shows up one cycle later. That choice may be the wrong direction, a missed nibble carry, a lost load or a skipped restart. A broken clear shows up immediately, with no clock needed. A fault in the all-ones detection is visible on all_ones_n in the same cycle. It also misroutes the carry to the high nibble on the next edge.

// File: rtl/lud_cnt_pkg.sv
package lud_cnt_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;

  function automatic logic is_full4(input logic [3:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/nib_counter.sv
module nib_counter
  import lud_cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         dir_up,
  input  logic         load_n,
  input  logic         en_n,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] val,
  output logic         full_n
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  dir_e dir;
  assign dir = dir_e'(dir_up);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      val <= '0;
    end else if (!en_n) begin
      if (!load_n)            val <= load_val;
      else if (dir == DIR_UP) val <= val + ONE;
      else                    val <= val - ONE;
    end
  end

  assign full_n = ~(&val);

  // R4: a disabled stage keeps its value
  a_r4_hold: assert property (@(posedge clk) disable iff (clr)
    en_n |=> $stable(val));
  // R5: an enabled load takes the parallel value
  a_r5_load: assert property (@(posedge clk) disable iff (clr)
    (!en_n && !load_n) |=> (val == $past(load_val)));
  // R2: enabled up count
  a_r2_up: assert property (@(posedge clk) disable iff (clr)
    (!en_n && load_n && dir_up) |=> (val == $past(val) + ONE));
  // R2: enabled down count
  a_r2_down: assert property (@(posedge clk) disable iff (clr)
    (!en_n && load_n && !dir_up) |=> (val == $past(val) - ONE));
  // R8: clear dominates at every edge it covers
  a_r8_clr: assert property (@(posedge clk) clr |-> (val == '0));
endmodule

// File: rtl/cascade_link.sv
module cascade_link #(
  parameter int N = 2
) (
  input  logic         en_n,
  input  logic         ld_eff_n,
  input  logic [N-1:0] stage_full_n,
  output logic [N-1:0] stage_en_n,
  output logic         chain_full_n
);
  logic [N:0] below_full;
  assign below_full[0] = 1'b1;

  for (genvar k = 0; k < N; k++) begin : g_link
    assign below_full[k+1] = below_full[k] & ~stage_full_n[k];
    // a load enables every stage; counting only those whose lower stages are full
    assign stage_en_n[k]   = en_n | (ld_eff_n & ~below_full[k]);
  end

  assign chain_full_n = ~below_full[N];
endmodule

// File: rtl/restart_sel.sv
module restart_sel #(
  parameter int W = 8
) (
  input  logic         load_n,
  input  logic         wrap_en,
  input  logic         chain_full_n,
  input  logic [W-1:0] load_data,
  input  logic [W-1:0] restart_val,
  output logic         ld_eff_n,
  output logic [W-1:0] ld_val
);
  logic wrap_hit;
  assign wrap_hit = wrap_en & ~chain_full_n;
  assign ld_eff_n = load_n & ~wrap_hit;
  assign ld_val   = (!load_n) ? load_data : restart_val;
endmodule

// File: rtl/lud_counter_chain.sv
module lud_counter_chain
  import lud_cnt_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int NIBS  = 2
) (
  input  logic                  clk,
  input  logic                  clr,
  input  logic                  dir_up,
  input  logic                  load_n,
  input  logic                  cnt_en_n,
  input  logic                  wrap_en,
  input  logic [NIB_W*NIBS-1:0] load_data,
  input  logic [NIB_W*NIBS-1:0] restart_val,
  output logic [NIB_W*NIBS-1:0] count,
  output logic                  all_ones_n
);
  localparam int WIDTH = NIB_W * NIBS;

  logic             ld_eff_n;
  logic [WIDTH-1:0] ld_val;
  logic [NIBS-1:0]  stage_en_n;
  logic [NIBS-1:0]  stage_full_n;

  restart_sel #(.W(WIDTH)) u_sel (
    .load_n      (load_n),
    .wrap_en     (wrap_en),
    .chain_full_n(all_ones_n),
    .load_data   (load_data),
    .restart_val (restart_val),
    .ld_eff_n    (ld_eff_n),
    .ld_val      (ld_val)
  );

  cascade_link #(.N(NIBS)) u_link (
    .en_n        (cnt_en_n),
    .ld_eff_n    (ld_eff_n),
    .stage_full_n(stage_full_n),
    .stage_en_n  (stage_en_n),
    .chain_full_n(all_ones_n)
  );

  for (genvar k = 0; k < NIBS; k++) begin : g_stage
    nib_counter #(.W(NIB_W)) u_nib (
      .clk     (clk),
      .clr     (clr),
      .dir_up  (dir_up),
      .load_n  (ld_eff_n),
      .en_n    (stage_en_n[k]),
      .load_val(ld_val[k*NIB_W +: NIB_W]),
      .val     (count[k*NIB_W +: NIB_W]),
      .full_n  (stage_full_n[k])
    );
  end

  // R6: the all-ones flag tracks the count at the top level
  always_comb begin
    if (!clr) a_r6_flag: assert ((all_ones_n == 1'b0) == (count == '1));
  end
  // R7: the all-ones state with wrap enabled restarts from restart_val
  a_r7_wrap: assert property (@(posedge clk) disable iff (clr)
    (wrap_en && !cnt_en_n && load_n && !all_ones_n) |=> (count == $past(restart_val)));
  // R3: upper nibbles hold while the low nibble is not full
  a_r3_hold_hi: assert property (@(posedge clk) disable iff (clr)
    (!cnt_en_n && load_n && !is_full4(count[3:0]))
    |=> $stable(count[WIDTH-1:NIB_W]));
endmodule

// File: tb/sim_lud_counter_chain.sv
`timescale 1ns/1ps
module sim_lud_counter_chain;
  logic clk = 1'b0;
  logic clr = 1'b0, dir_up = 1'b1, load_n = 1'b1, cnt_en_n = 1'b1, wrap_en = 1'b0;
  logic [7:0] load_data = '0, restart_val = '0;
  logic [7:0] count;
  logic all_ones_n;
  int checks = 0, fails = 0;
  logic [7:0] mq;
  bit finished = 0;

  always #2 clk = ~clk;

  lud_counter_chain u0 (
    .clk(clk), .clr(clr), .dir_up(dir_up), .load_n(load_n), .cnt_en_n(cnt_en_n),
    .wrap_en(wrap_en), .load_data(load_data), .restart_val(restart_val),
    .count(count), .all_ones_n(all_ones_n)
  );

  function automatic logic [7:0] next_val(input logic [7:0] q, input logic up,
      input logic ldn, input logic enn, input logic wr, input logic [7:0] d,
      input logic [7:0] rs);
    logic [3:0] lo, hi;
    if (enn) return q;
    if (!ldn) return d;
    if (wr && q == 8'hFF) return rs;
    lo = up ? q[3:0] + 4'd1 : q[3:0] - 4'd1;
    hi = q[7:4];
    if (q[3:0] == 4'hF) hi = up ? hi + 4'd1 : hi - 4'd1;
    return {hi, lo};
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (count !== exp) begin
      fails++;
      $display("FAIL %s count=%02h expected=%02h", tag, count, exp);
    end
    checks++;
    if (all_ones_n !== (exp != 8'hFF)) begin
      fails++;
      $display("FAIL R6 (%s) all_ones_n=%0b expected=%0b", tag, all_ones_n, exp != 8'hFF);
    end
  endtask

  task automatic cyc(input string tag, input logic up, input logic ldn, input logic enn,
      input logic wr, input logic [7:0] d, input logic [7:0] rs);
    @(negedge clk);
    dir_up = up; load_n = ldn; cnt_en_n = enn; wrap_en = wr; load_data = d; restart_val = rs;
    mq = next_val(mq, up, ldn, enn, wr, d, rs);
    @(posedge clk); #1;
    check(tag, mq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    @(negedge clk); clr = 1'b1; #1;
    mq = 8'h00; check("R1 reset", mq);
    @(negedge clk); clr = 1'b0;

    // R2/R3 up through 0x0F and wrap 0xFF->0x00
    cyc("R5 load 0E", 1, 0, 0, 0, 8'h0E, 8'h00);
    cyc("R2 up", 1, 1, 0, 0, 8'h00, 8'h00);
    cyc("R3 carry to high", 1, 1, 0, 0, 8'h00, 8'h00);
    cyc("R5 load FE", 1, 0, 0, 0, 8'hFE, 8'h00);
    cyc("R2 up to FF", 1, 1, 0, 0, 8'h00, 8'h00);
    cyc("R3 wrap to 00", 1, 1, 0, 0, 8'h00, 8'h00);
    // R2/R3 down corners
    cyc("R2 down 00", 0, 1, 0, 0, 8'h00, 8'h00);
    cyc("R3 down low full", 0, 1, 0, 0, 8'h00, 8'h00);
    // R4 disabled: load and wrap ignored
    cyc("R4 hold with load", 1, 0, 1, 1, 8'h5A, 8'h33);
    cyc("R4 hold", 0, 1, 1, 0, 8'hA5, 8'h00);
    // R6 at FF counting down keeps flag independent of direction
    cyc("R5 load FF", 0, 0, 0, 0, 8'hFF, 8'h00);
    cyc("R4 hold FF", 0, 1, 1, 1, 8'h00, 8'h06);
    // R7 restart wrap, both directions
    cyc("R7 wrap up", 1, 1, 0, 1, 8'h00, 8'h06);
    cyc("R5 load FF", 1, 0, 0, 1, 8'hFF, 8'h06);
    cyc("R5 load beats wrap", 1, 0, 0, 1, 8'h21, 8'h06);
    cyc("R5 load FF", 1, 0, 0, 1, 8'hFF, 8'h06);
    cyc("R7 wrap down", 0, 1, 0, 1, 8'h00, 8'h96);
    // R1/R8 clear mid-cycle, held across an edge with load requested
    @(negedge clk); dir_up = 1; load_n = 0; cnt_en_n = 0; load_data = 8'h77;
    #0.5 clr = 1'b1; #0.5;
    mq = 8'h00; check("R1 async clear", mq);
    @(posedge clk); #1; check("R8 clear beats load", mq);
    @(negedge clk); #1 clr = 1'b0; load_n = 1;
    @(posedge clk); #1;
    mq = 8'h01; check("R2 after clear", mq);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic up, ldn, enn, wr;
      logic [7:0] d, rs;
      up  = 1'($urandom);
      ldn = ($urandom % 10) != 0;
      enn = ($urandom % 8) == 0;
      wr  = ($urandom % 3) == 0;
      d   = (($urandom % 4) == 0) ? 8'hFE : 8'($urandom);
      rs  = 8'($urandom);
      cyc("R2/R3/R4/R5/R7 random", up, ldn, enn, wr, d, rs);
    end

    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule